// File: doc/BRIEF.md
# Loadable Coarse Delay Counter

The block measures out a programmable delay in whole periods of the system clock. A host writes a delay count N onto a parallel bus and pulses a load strobe. An external sequencer then asserts a count enable. After N enabled clock edges the block raises a single-cycle done pulse on the clock edge that follows the terminal count. The counter steps only on edges that a load or a count enable qualifies. This gating acts as the clock gate, so idle cycles leave the count frozen.

Internally the count runs upward from the preset 2^W − N toward the all-ones state. A narrow low-order prescaler supplies the carry to a wider upper stage, and terminal count is the AND of the two stages' all-ones flags. A load arms the counter. The done pulse disarms it, and further count enables have no effect until the next load. With the default W = 24 at 39.0625 MHz, one step is 25.6 ns and the longest delay is about 429 ms.

Top module: `coarse_delay`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, done and busy are both 0.
- R2: After a load of N ≥ 1, done is 1 for the cycle that follows the Nth enabled count edge, and it is 0 before that.
- R3: A clock edge with load = 0 and count_en = 0 does not advance the count. Any number of idle cycles between enabled edges leaves the edge at which done rises, counted in enabled edges, unchanged.
- R4: Load takes priority over count_en on the same edge. It restarts the count from the new value and clears done and busy.
- R5: A loaded value of 0 produces done after the first enabled count edge.
- R6: busy is 1 after the kth enabled edge for 1 ≤ k < N, and it is 0 otherwise. busy and done are never 1 together.
- R7: count_en has no effect while the counter is disarmed, both after reset before any load and after done until the next load. In these states done and busy stay 0.
- R8: done never lasts longer than one cycle.
- R9: The largest value, N = 2^W − 1, produces done after exactly 2^W − 1 enabled edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | Load strobe, sampled on the clock edge |
| delay_val | input | W | Delay count N in clock periods |
| count_en | input | 1 | Count enable from the sequencer |
| done | output | 1 | One-cycle pulse after the delay expires |
| busy | output | 1 | Count in progress |

## Verification
The assertions check every cycle that done is one cycle wide, that done and busy never coincide, that a load always clears both outputs, and that an idle or disarmed edge never raises done. Only the bench's scenarios show that done arrives after exactly N enabled edges. The scenarios cover sparse enable patterns, the zero and full-scale values, and a reload in mid-count.

// File: rtl/coarse_delay.sv
module coarse_delay #(
  parameter int W  = 24,
  parameter int PW = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] delay_val,
  input  logic         count_en,
  output logic         done,
  output logic         busy
);
  localparam int HW = W - PW;

  logic [PW-1:0] lo;
  logic [HW-1:0] hi;
  logic          armed;

  wire           tick   = load | (count_en & armed);
  wire           lo_tc  = &lo;
  wire           hi_tc  = &hi;
  wire           full   = lo_tc & hi_tc;
  wire           zero   = ~|{hi, lo};
  wire [W-1:0]   preset = ~delay_val + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo    <= '0;
      hi    <= '0;
      armed <= 1'b0;
      done  <= 1'b0;
      busy  <= 1'b0;
    end else if (tick) begin
      if (load) begin
        {hi, lo} <= preset;
        armed    <= 1'b1;
        done     <= 1'b0;
        busy     <= 1'b0;
      end else if (full || zero) begin
        armed <= 1'b0;
        done  <= 1'b1;
        busy  <= 1'b0;
      end else begin
        lo   <= lo + 1'b1;
        if (lo_tc) hi <= hi + 1'b1;
        busy <= 1'b1;
        done <= 1'b0;
      end
    end else begin
      done <= 1'b0;
    end
  end

  p_done_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_busy_done_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done);
  p_load_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (!done && !busy));
  p_idle_no_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !count_en) |=> !done);
  p_disarmed_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !load) |=> (!done && !busy));
endmodule

// File: tb/coarse_delay_test.sv
module coarse_delay_test;
  localparam int CLK_P = 10;
  localparam int W     = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load = 1'b0;
  logic [W-1:0] delay_val = '0;
  logic count_en = 1'b0;
  logic done, busy;
  int n_checks = 0;
  int n_fail   = 0;

  // each row: delay N, enable period (count_en high once every 'period' cycles)
  localparam int VEC [7][2] = '{'{5,1}, '{3,2}, '{1,1}, '{0,1}, '{7,3}, '{2,1}, '{9,4}};

  coarse_delay #(.W(W), .PW(4)) uut (
    .clk(clk), .rst_n(rst_n), .load(load), .delay_val(delay_val),
    .count_en(count_en), .done(done), .busy(busy)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {done,busy} actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_load(input int n);
    @(negedge clk);
    load = 1'b1; delay_val = n[W-1:0]; count_en = 1'b0;
    @(negedge clk);
    load = 1'b0;
    check("R4 load clears", {done, busy}, 2'b00);
  endtask

  // R2 R3 R5 R6 R8 R7: walk enables, predict outputs after every edge
  task automatic run(input int n, input int per, input int extra, input string req);
    int e = 0;
    int target = (n == 0) ? 1 : n;
    int cycles = target * per + extra;
    do_load(n);
    for (int i = 0; i < cycles; i++) begin
      logic en = (i % per) == 0;
      logic [1:0] exp;
      count_en = en;
      @(negedge clk);
      if (en) e++;
      exp[1] = en && (e == target);
      exp[0] = (e >= 1) && (e < target);
      check(req, {done, busy}, exp);
    end
    count_en = 1'b0;
  endtask

  initial begin
    #(CLK_P * 150000);
    n_fail++; n_checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    logic seen;
    repeat (3) @(negedge clk);
    check("R1 in reset", {done, busy}, 2'b00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", {done, busy}, 2'b00);

    // R7: enables before any load do nothing
    seen = 1'b0;
    count_en = 1'b1;
    repeat (20) begin @(negedge clk); seen |= done | busy; end
    count_en = 1'b0;
    check("R7 no load", {seen, 1'b0}, 2'b00);

    for (int v = 0; v < 7; v++)
      run(VEC[v][0], VEC[v][1], 6, "R2/R3/R6/R8/R7 table");

    run(0, 2, 4, "R5 zero value");
    run((1 << W) - 1, 1, 3, "R9 full scale");

    // R4: reload in mid-count with count_en also high
    do_load(4);
    count_en = 1'b1;
    repeat (2) @(negedge clk);
    check("R4 mid-count busy", {done, busy}, 2'b01);
    load = 1'b1; delay_val = 3;
    @(negedge clk);
    load = 1'b0;
    check("R4 priority", {done, busy}, 2'b00);
    @(negedge clk); check("R4 restart e1", {done, busy}, 2'b01);
    @(negedge clk); check("R4 restart e2", {done, busy}, 2'b01);
    @(negedge clk); check("R4 restart e3", {done, busy}, 2'b10);
    @(negedge clk); check("R7 after done", {done, busy}, 2'b00);
    count_en = 1'b0;

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule